// File: doc/BRIEF.md
# Clock-Distribution Configuration Slave

This block is the two-wire serial configuration port of a clock fan-out device. An external host programs it with block writes and checks it with block reads. The block holds eight 8-bit configuration bytes. Two of them gate the device's outputs, which are six differential DDR clock pairs and thirteen single-ended SDRAM clocks. One bit reports the level of an external mode-select pin.

SCL and SDA are sampled on a fast system clock. START and STOP are decoded from the sampled levels. The serial data output is open-drain: `sda_oe` high pulls the line low. A write carries an address byte, then two bytes that are acknowledged and thrown away, then data that fills byte 0, byte 1 and so on. A read returns a length byte and then the eight configuration bytes in order. Every enable is a flop output, so the clock-gating cells downstream see steady levels.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges address byte 0xD4 (write) and 0xD5 (read), each counted with its R/W bit. Any other address gets no acknowledge, and the bytes that follow it change nothing until the next START.
- R2: In a write, the two bytes after the address are acknowledged and have no effect on any register.
- R3: Write data goes to byte 0, then byte 1, and so on, one byte each. A STOP after any complete byte leaves the bytes not reached unchanged. The enable outputs change only on a stored write.
- R4: Every byte of a write is acknowledged. After a STOP the slave releases SDA.
- R5: A read returns 0x08 first, then bytes 0 to 7. Each byte is sent MSB first.
- R6: In byte 6, bit 7 reads the mode-select pin and bits 6 and 0 read 0. Writes to these three bits have no effect. Bits 5..1 drive DDR pair enables 5..1.
- R7: In byte 7, bit 7 drives the DDR pair 0 enable and bit 6 drives SDRAM output 12. Bit k (k = 0..5) drives SDRAM outputs 2k and 2k+1. For every enable, 1 means on.
- R8: Reset sets all enables to 1 and bytes 0 to 5 to 0xFF.
- R9: If the host does not acknowledge a read byte, the slave releases SDA and stays silent until STOP. The next transfer then works normally.
- R10: Apart from START and STOP handling, SDA output changes only while SCL is low.
- R11: Data bytes past byte 7 are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| mode_sel_i | input | 1 | Mode-select pin (1 = DDR mode), read back only |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ddr_en | output | 6 | DDR pair enables, bit n for pair n |
| sdr_en | output | 13 | SDRAM output enables, bit n for output n |

## Verification
Two functions can land in the same cycle. One is a stored write that moves an enable output. The other is the acknowledge drive on SDA for that same byte: the eighth SCL rise both latches the byte and queues the acknowledge. The bench runs full-length, partial and overlong writes with arithmetic data patterns. It requires the acknowledge of every byte. It then compares the enable outputs and a complete readback against a model of the register bytes. A monitor checks that SDA never moves while the bench holds SCL high. A checker requires that the enables change only in the cycle after a write strobe.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_BYTES  = 8;
  localparam int DDR_PAIRS  = 6;
  localparam int SDR_OUTS   = 13;
  localparam int DDR_BYTE   = 6;
  localparam int MIX_BYTE   = 7;
  localparam logic [7:0] DDR_WMASK = 8'h3E;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_WR, S_ACK_ON, S_ACK_OFF,
    S_RD, S_MACK_OFF, S_MACK, S_RD_NEXT, S_WAIT
  } link_state_t;
endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/clkcfg_link.sv
module clkcfg_link
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int IW = $clog2(NUM_BYTES),
  parameter int BW = $clog2(NUM_BYTES + 4) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);
  link_state_t state;
  logic [2:0]    bitcnt;
  logic [6:0]    shreg;
  logic [7:0]    txreg;
  logic          is_rd;
  logic [BW-1:0] bidx;
  logic [BW-1:0] data_pos, rd_pos;
  logic [7:0]    tx_next, rx_byte;
  logic          data_ok;

  assign rx_byte  = {shreg, sda_lvl};
  assign data_pos = bidx - BW'(2);
  assign data_ok  = (bidx >= BW'(2)) && (data_pos < BW'(NUM_BYTES));
  assign rd_pos   = bidx - BW'(1);
  assign rd_idx   = rd_pos[IW-1:0];
  assign tx_next  = (bidx == '0) ? 8'(NUM_BYTES) :
                    (rd_pos < BW'(NUM_BYTES)) ? rd_data : 8'hFF;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      is_rd   <= 1'b0;
      bidx    <= '0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        bidx   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              is_rd <= sda_lvl;
              state <= (shreg == DEV_ADDR) ? S_ACK_ON : S_IDLE;
            end
          end
          S_WR: if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (data_ok) begin
                wr_stb  <= 1'b1;
                wr_idx  <= data_pos[IW-1:0];
                wr_data <= rx_byte;
              end
              if (bidx != '1) bidx <= bidx + BW'(1);
              state <= S_ACK_ON;
            end
          end
          S_ACK_ON: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= S_ACK_OFF;
          end
          S_ACK_OFF: if (scl_fall) begin
            bitcnt <= '0;
            if (is_rd) begin
              txreg  <= tx_next;
              sda_oe <= ~tx_next[7];
              state  <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_WR;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) state <= S_MACK_OFF;
            end else if (scl_fall) begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
          S_MACK_OFF: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_MACK;
          end
          S_MACK: if (scl_rise) begin
            if (!sda_lvl) begin
              if (bidx != '1) bidx <= bidx + BW'(1);
              state <= S_RD_NEXT;
            end else begin
              state <= S_WAIT;
            end
          end
          S_RD_NEXT: if (scl_fall) begin
            txreg  <= tx_next;
            sda_oe <= ~tx_next[7];
            bitcnt <= '0;
            state  <= S_RD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int IW = $clog2(NUM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [IW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IW-1:0]        rd_idx,
  input  logic                 mode_lvl,
  output logic [7:0]           rd_data,
  output logic [DDR_PAIRS-1:0] ddr_en,
  output logic [SDR_OUTS-1:0]  sdr_en
);
  logic [7:0] mem [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (wr_stb) begin
      mem[wr_idx] <= (wr_idx == IW'(DDR_BYTE)) ? (wr_data & DDR_WMASK) : wr_data;
    end
  end

  always_comb begin
    if (rd_idx == IW'(DDR_BYTE))
      rd_data = (mem[DDR_BYTE] & DDR_WMASK) | {mode_lvl, 7'b0};
    else
      rd_data = mem[rd_idx];
  end

  assign ddr_en[DDR_PAIRS-1:1] = mem[DDR_BYTE][DDR_PAIRS-1:1];
  assign ddr_en[0]             = mem[MIX_BYTE][7];
  assign sdr_en[SDR_OUTS-1]    = mem[MIX_BYTE][6];

  for (genvar k = 0; k < (SDR_OUTS - 1) / 2; k++) begin : g_sdr_pair
    assign sdr_en[2*k+1:2*k] = {2{mem[MIX_BYTE][k]}};
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 mode_sel_i,
  output logic                 sda_oe,
  output logic [DDR_PAIRS-1:0] ddr_en,
  output logic [SDR_OUTS-1:0]  sdr_en
);
  localparam int IW = $clog2(NUM_BYTES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  logic [SYNC_STAGES-1:0] mode_sh;

  always_ff @(posedge clk) begin
    if (rst) mode_sh <= '0;
    else     mode_sh <= {mode_sh[SYNC_STAGES-2:0], mode_sel_i};
  end

  clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  clkcfg_link #(.DEV_ADDR(DEV_ADDR), .IW(IW)) u_link (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_idx(rd_idx), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  clkcfg_regs #(.IW(IW)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .mode_lvl(mode_sh[SYNC_STAGES-1]),
    .rd_data(rd_data), .ddr_en(ddr_en), .sdr_en(sdr_en)
  );
endmodule

// File: rtl/clkcfg_chk.sv
module clkcfg_chk
  import clkcfg_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 scl_lvl,
  input logic                 start_det,
  input logic                 stop_det,
  input logic                 sda_oe,
  input logic                 wr_stb,
  input logic [DDR_PAIRS-1:0] ddr_en,
  input logic [SDR_OUTS-1:0]  sdr_en
);
  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R8
  reset_default_chk: assert property (@(posedge clk)
    rst |=> ((&ddr_en) && (&sdr_en) && !sda_oe));

  // R10
  sda_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  // R3
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ddr_en) || !$stable(sdr_en)) |-> $past(wr_stb));
endmodule

bind clkcfg_i2c_slave clkcfg_chk u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_stb(wr_stb),
  .ddr_en(ddr_en), .sdr_en(sdr_en)
);

// File: tb/clkcfg_i2c_slave_tb.sv
module clkcfg_i2c_slave_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, scl_m, sda_m, mode_pin;
  logic sda_oe;
  logic [5:0] ddr_en;
  logic [12:0] sdr_en;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_mem [8];

  clkcfg_i2c_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .mode_sel_i(mode_pin), .sda_oe(sda_oe), .ddr_en(ddr_en), .sdr_en(sdr_en)
  );

  // R10 monitor: SDA output must not move while SCL is held high
  always @(negedge clk) begin
    if (!rst && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw(1);
    sda_m = 1'b0; qw(1);
    scl_m = 1'b0; qw(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(1);
    scl_m = 1'b1; qw(1);
    sda_m = 1'b1; qw(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(1);
      scl_m = 1'b1; qw(2);
      scl_m = 1'b0; qw(1);
    end
    sda_m = 1'b1; qw(1);
    scl_m = 1'b1; qw(1);
    acked = !sda_line;
    qw(1);
    scl_m = 1'b0; qw(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(1);
      scl_m = 1'b1; qw(1);
      b[i] = sda_line;
      qw(1);
      scl_m = 1'b0; qw(1);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; qw(1);
    scl_m = 1'b1; qw(2);
    scl_m = 1'b0; qw(1);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] rb(input int i);
    if (i == 6) return (exp_mem[6] & 8'h3E) | {mode_pin, 7'b0};
    return exp_mem[i];
  endfunction

  task automatic check_outs(input string req);
    logic [5:0] ed;
    logic [12:0] es;
    ed = {exp_mem[6][5:1], exp_mem[7][7]};
    es[12] = exp_mem[7][6];
    for (int k = 0; k < 6; k++) es[2*k +: 2] = {2{exp_mem[7][k]}};
    chk(ddr_en == ed, req, 32'(ddr_en), 32'(ed));
    chk(sdr_en == es, req, 32'(sdr_en), 32'(es));
  endtask

  task automatic write_seq(input int n, input logic [7:0] base, input logic [7:0] step, input string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD4, a);        chk(a, {req, " R1 addr ack"}, 32'(a), 1);
    send_byte(8'h5A ^ base, a); chk(a, {req, " R2 cmd ack"}, 32'(a), 1);
    send_byte(8'h03 + step, a); chk(a, {req, " R2 count ack"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      d = base + step * 8'(i);
      send_byte(d, a);
      chk(a, {req, " R4 data ack"}, 32'(a), 1);
      if (i < 8) exp_mem[i] = (i == 6) ? (d & 8'h3E) : d;
    end
    bus_stop();
  endtask

  task automatic read_check(input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD5, a); chk(a, {req, " R1 read addr ack"}, 32'(a), 1);
    recv_byte(1'b1, b);  chk(b == 8'h08, {req, " R5 count"}, 32'(b), 8);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, b);
      chk(b == rb(i), {req, " R5 byte"}, 32'(b), 32'(rb(i)));
    end
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; mode_pin = 1'b1;
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R8 reset state
    check_outs("R8 reset enables");
    chk(sda_oe == 1'b0, "R8 sda idle", 32'(sda_oe), 0);
    read_check("R8 reset readback");

    // R3 R6 R7 full writes with arithmetic patterns
    for (int n = 0; n < 6; n++) begin
      write_seq(8, 8'(n * 37 + 5), 8'(n * 29 + 11), "R3 sweep");
      check_outs("R7 R6 sweep outputs");
      read_check("R3 sweep readback");
    end

    // R3 partial writes of growing length, including none
    for (int len = 0; len < 8; len++) begin
      write_seq(len, 8'(len * 61 + 3), 8'h47, "R3 partial");
      check_outs("R3 partial outputs");
      read_check("R3 partial readback");
    end

    // R11 overlong write
    write_seq(11, 8'hC3, 8'h1D, "R11 overlong");
    check_outs("R11 overlong outputs");
    read_check("R11 overlong readback");

    // R1 foreign addresses
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1 foreign addr nack", 32'(a), 0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h00, a);
    chk(!a, "R1 no ack after foreign addr", 32'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'hD6, a); chk(!a, "R1 near addr nack", 32'(a), 0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h00, a);
    bus_stop();
    check_outs("R1 outputs unchanged");
    read_check("R1 readback unchanged");

    // R6 mode pin readback and read-only bits
    mode_pin = 1'b0;
    repeat (4) @(negedge clk);
    write_seq(8, 8'hFF, 8'h00, "R6 all ones");
    check_outs("R6 outputs");
    read_check("R6 mode low readback");
    mode_pin = 1'b1;
    repeat (4) @(negedge clk);
    read_check("R6 mode high readback");

    // R9 host NACK ends read early
    bus_start();
    send_byte(8'hD5, a); chk(a, "R9 addr ack", 32'(a), 1);
    recv_byte(1'b1, b);  chk(b == 8'h08, "R9 count", 32'(b), 8);
    recv_byte(1'b0, b);  chk(b == rb(0), "R9 byte0", 32'(b), 32'(rb(0)));
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1);
      chk(sda_line == 1'b1, "R9 released after nack", 32'(sda_line), 1);
      qw(1); scl_m = 1'b0; qw(1);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R4 released after stop", 32'(sda_oe), 0);
    read_check("R9 read after nack");

    // R8 reset mid-run
    write_seq(8, 8'h00, 8'h00, "R8 clear");
    check_outs("R8 cleared outputs");
    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'hFF;
    check_outs("R8 re-reset enables");
    read_check("R8 re-reset readback");

    chk(viol == 0, "R10 sda moved with scl high", 32'(viol), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule